// File: doc/BRIEF.md
# Smart card session control interface

This block sits between a host controller and the contact interface of a smart card reader. It takes the host's control pins (activation request, card reset, power-down, chip select and supply voltage select). It also takes a card-detect input and three supply fault inputs: supply voltage, thermal and over-current. From these it runs a small session sequencer: IDLE, ACTIVATING, ACTIVE, DEACTIVATING and POWERDOWN. Activation and deactivation are fixed-length phases timed by a counter. Analog supply ramping is not modelled.

A single active-low status pin serves two purposes. While the host is not requesting activation, the pin shows whether a card is inserted. While activation is requested, a low level on the pin means a fault was latched during the session. Any fault in a session sends the sequencer into deactivation without help from the host. The card reset output follows the host reset pin only while the session is active.

When the host drops chip select, the block holds its last host commands. It releases the status pin, which is shown by an output-enable going low, and it asks for weak pull-ups on the host data and auxiliary lines. All pins are plain level signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `sc_session_ctl`

## Requirements
- R1: With a card detected and activation allowed, a low activation request moves `seq_state` from IDLE (0) to ACTIVATING (1) two clock edges after the pin changes. It reaches ACTIVE (2) after ACT_CYCLES more edges. `card_vcc_en` is high in ACTIVATING and ACTIVE only.
- R2: A low activation request while no card is detected leaves `seq_state` at IDLE (0).
- R3: While the held activation request is high, `status_n` equals the synchronized card-detect level (low means no card).
- R4: While the held activation request is low, `status_n` is low exactly when the fault latch is set. Each fault source sets the latch: card removal, supply voltage fault, thermal fault and over-current fault.
- R5: Any fault during ACTIVATING or ACTIVE moves `seq_state` to DEACTIVATING (3) three edges after the fault pin changes, with no host action. `session_active` and `card_vcc_en` drop at that edge.
- R6: DEACTIVATING lasts DEACT_CYCLES edges and then returns to IDLE. Raising the activation request while in ACTIVE also enters DEACTIVATING, two edges after the pin changes.
- R7: The fault latch stays set through deactivation and IDLE until the host raises the activation request. While it is set, a held low request does not start a new activation.
- R8: `card_rst` equals the held host reset input while in ACTIVE and is low in every other state.
- R9: A power-down request in IDLE enters POWERDOWN (4) two edges later and leaves it when the request drops. A power-down request in ACTIVE is ignored. An activation request in POWERDOWN is ignored. In IDLE, a valid activation request takes priority over power-down.
- R10: While `cs` is low, `status_oe` is low and `host_pull_en` is high. All host command inputs (request, reset, power-down, voltage select) are frozen at their last values. One edge after `cs` rises, the commands follow the pins again.
- R11: Card-detect and fault inputs pass through a two-flop synchronizer. A card-detect change reaches `status_n` two edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, high = host pins live |
| act_req_n | input | 1 | Activation request, active low |
| host_rst | input | 1 | Host-driven card reset level |
| pwrdn_req | input | 1 | Power-down request, active high |
| vsel | input | 1 | Card supply voltage select |
| card_det | input | 1 | Card presence, high = inserted (asynchronous) |
| vcc_fault | input | 1 | Supply voltage fault (asynchronous) |
| therm_fault | input | 1 | Thermal fault (asynchronous) |
| ocp_fault | input | 1 | Over-current fault (asynchronous) |
| status_n | output | 1 | Presence / fault status, active low |
| status_oe | output | 1 | Status pin drive enable (low = high impedance) |
| host_pull_en | output | 1 | Weak pull-up enable for host data and auxiliary lines |
| card_rst | output | 1 | Gated card reset |
| card_vcc_en | output | 1 | Card supply enable |
| card_vsel | output | 1 | Held voltage select toward the supply |
| session_active | output | 1 | High in ACTIVE |
| seq_state | output | 3 | Sequencer state: 0 IDLE, 1 ACTIVATING, 2 ACTIVE, 3 DEACTIVATING, 4 POWERDOWN |

## Verification
A wrong sequencer state is visible on `seq_state`, `session_active` and `card_vcc_en` on the edge where the transition should have happened. The bench therefore checks every transition on the exact edge count that follows from the one-edge command hold and the two-flop synchronizer. A fault latch that clears too early or fails to set shows on `status_n` within three edges of a fault. It also shows as an unwanted re-activation while the request is still held low. A broken chip-select freeze appears within two edges of `cs` rising, as a state change or a `card_vsel` change that should not happen.

// File: rtl/sc_session_pkg.sv
package sc_session_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACTIVATING = 3'd1,
    ST_ACTIVE     = 3'd2,
    ST_DEACT      = 3'd3,
    ST_PWRDN      = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic req_n;
    logic rst_lvl;
    logic pwrdn;
    logic vsel;
  } host_cmd_t;

  localparam host_cmd_t HOST_CMD_RESET = '{req_n: 1'b1, rst_lvl: 1'b0, pwrdn: 1'b0, vsel: 1'b0};

  localparam int SENSE_W   = 4;
  localparam int SENSE_DET = 3;
  localparam int SENSE_VCC = 2;
  localparam int SENSE_TH  = 1;
  localparam int SENSE_OC  = 0;

endpackage

// File: rtl/sc_sync2.sv
module sc_sync2 #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[gi];
          stab_q <= RST_VAL[gi];
        end else begin
          meta_q <= d[gi];
          stab_q <= meta_q;
        end
      end
      assign q[gi] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/sc_host_hold.sv
module sc_host_hold
  import sc_session_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs,
  input  host_cmd_t cmd_in,
  output host_cmd_t cmd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= HOST_CMD_RESET;
    end else if (cs) begin
      cmd_q <= cmd_in;
    end
  end

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_session_pkg::*;
#(
  parameter int ACT_CYCLES   = 6,
  parameter int DEACT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_n,
  input  logic       pwrdn,
  input  logic       card_in,
  input  logic       sess_fault,
  output seq_state_e state,
  output logic       fault_lat
);

  localparam int MAX_CYC = (ACT_CYCLES > DEACT_CYCLES) ? ACT_CYCLES : DEACT_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ACT_LAST   = CNT_W'(ACT_CYCLES - 1);
  localparam logic [CNT_W-1:0] DEACT_LAST = CNT_W'(DEACT_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_session;
  logic             lat_set, lat_clr;

  assign in_session = (state_q == ST_ACTIVATING) || (state_q == ST_ACTIVE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!req_n && card_in && !fault_lat) begin
          state_d = ST_ACTIVATING;
        end else if (pwrdn) begin
          state_d = ST_PWRDN;
        end
      end
      ST_ACTIVATING: begin
        if (sess_fault) begin
          state_d = ST_DEACT;
          cnt_d   = '0;
        end else if (cnt_q == ACT_LAST) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ACTIVE: begin
        cnt_d = '0;
        if (sess_fault || req_n) begin
          state_d = ST_DEACT;
        end
      end
      ST_DEACT: begin
        if (cnt_q == DEACT_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PWRDN: begin
        cnt_d = '0;
        if (!pwrdn) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign lat_set = in_session && sess_fault;
  assign lat_clr = (state_q == ST_IDLE) && req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_lat <= 1'b0;
    end else if (lat_set) begin
      fault_lat <= 1'b1;
    end else if (lat_clr) begin
      fault_lat <= 1'b0;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sc_session_ctl.sv
module sc_session_ctl
  import sc_session_pkg::*;
#(
  parameter int ACT_CYCLES   = 6,
  parameter int DEACT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       act_req_n,
  input  logic       host_rst,
  input  logic       pwrdn_req,
  input  logic       vsel,
  input  logic       card_det,
  input  logic       vcc_fault,
  input  logic       therm_fault,
  input  logic       ocp_fault,
  output logic       status_n,
  output logic       status_oe,
  output logic       host_pull_en,
  output logic       card_rst,
  output logic       card_vcc_en,
  output logic       card_vsel,
  output logic       session_active,
  output logic [2:0] seq_state
);

  host_cmd_t            cmd_in;
  host_cmd_t            cmd_q;
  logic [SENSE_W-1:0]   sense_raw;
  logic [SENSE_W-1:0]   sense_s;
  logic                 det_s;
  logic                 supply_fault;
  logic                 sess_fault;
  logic                 fault_lat;
  seq_state_e           state;

  assign cmd_in = '{req_n: act_req_n, rst_lvl: host_rst, pwrdn: pwrdn_req, vsel: vsel};

  sc_host_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .cmd_in (cmd_in),
    .cmd_q  (cmd_q)
  );

  always_comb begin
    sense_raw            = '0;
    sense_raw[SENSE_DET] = card_det;
    sense_raw[SENSE_VCC] = vcc_fault;
    sense_raw[SENSE_TH]  = therm_fault;
    sense_raw[SENSE_OC]  = ocp_fault;
  end

  sc_sync2 #(
    .WIDTH   (SENSE_W),
    .RST_VAL ('0)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sense_raw),
    .q     (sense_s)
  );

  assign det_s        = sense_s[SENSE_DET];
  assign supply_fault = sense_s[SENSE_VCC] | sense_s[SENSE_TH] | sense_s[SENSE_OC];
  assign sess_fault   = !det_s || supply_fault;

  sc_seq_fsm #(
    .ACT_CYCLES   (ACT_CYCLES),
    .DEACT_CYCLES (DEACT_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (cmd_q.req_n),
    .pwrdn      (cmd_q.pwrdn),
    .card_in    (det_s),
    .sess_fault (sess_fault),
    .state      (state),
    .fault_lat  (fault_lat)
  );

  assign status_n       = cmd_q.req_n ? det_s : !fault_lat;
  assign status_oe      = cs;
  assign host_pull_en   = !cs;
  assign session_active = (state == ST_ACTIVE);
  assign card_rst       = (state == ST_ACTIVE) && cmd_q.rst_lvl;
  assign card_vcc_en    = (state == ST_ACTIVATING) || (state == ST_ACTIVE);
  assign card_vsel      = cmd_q.vsel;
  assign seq_state      = state;

endmodule

// File: rtl/sc_session_chk.sv
module sc_session_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       status_n,
  input logic       status_oe,
  input logic       card_rst,
  input logic       session_active,
  input logic [2:0] state,
  input logic       present_s,
  input logic       sess_fault,
  input logic       fault_lat,
  input logic       req_n_h
);

  p_no_card_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && !present_s) |=> (state != 3'd1));

  p_status_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n_h && fault_lat) |-> !status_n);

  p_fault_deact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && sess_fault) |=> (state == 3'd3));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_lat && !(state == 3'd0 && req_n_h)) |=> fault_lat);

  p_card_rst_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !session_active |-> !card_rst);

  p_pd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2) |=> (state != 3'd4));

  p_deselect_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !status_oe);

endmodule

bind sc_session_ctl sc_session_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cs             (cs),
  .status_n       (status_n),
  .status_oe      (status_oe),
  .card_rst       (card_rst),
  .session_active (session_active),
  .state          (seq_state),
  .present_s      (det_s),
  .sess_fault     (sess_fault),
  .fault_lat      (fault_lat),
  .req_n_h        (cmd_q.req_n)
);

// File: tb/sc_session_ctl_test.sv
`timescale 1ns/1ps
module sc_session_ctl_test;

  localparam int ACT = 6;
  localparam int DEA = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b1;
  logic       act_req_n = 1'b1;
  logic       host_rst = 1'b0;
  logic       pwrdn_req = 1'b0;
  logic       vsel = 1'b0;
  logic       card_det = 1'b0;
  logic       vcc_fault = 1'b0;
  logic       therm_fault = 1'b0;
  logic       ocp_fault = 1'b0;
  logic       status_n, status_oe, host_pull_en, card_rst;
  logic       card_vcc_en, card_vsel, session_active;
  logic [2:0] seq_state;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sc_session_ctl #(.ACT_CYCLES(ACT), .DEACT_CYCLES(DEA)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .act_req_n(act_req_n),
    .host_rst(host_rst), .pwrdn_req(pwrdn_req), .vsel(vsel),
    .card_det(card_det), .vcc_fault(vcc_fault), .therm_fault(therm_fault),
    .ocp_fault(ocp_fault), .status_n(status_n), .status_oe(status_oe),
    .host_pull_en(host_pull_en), .card_rst(card_rst), .card_vcc_en(card_vcc_en),
    .card_vsel(card_vsel), .session_active(session_active), .seq_state(seq_state)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic activate_full();
    card_det = 1'b1;
    step(3);
    act_req_n = 1'b0;
    step(1); chk("R1 still idle", seq_state, 0);
    step(1); chk("R1 activating", seq_state, 1);
    chk("R1 vcc on", card_vcc_en, 1);
    step(ACT - 1); chk("R1 activating end", seq_state, 1);
    step(1); chk("R1 active", seq_state, 2);
    chk("R1 session", session_active, 1);
  endtask

  task automatic release_to_idle();
    act_req_n = 1'b1;
    step(1); chk("R6 held active", seq_state, 2);
    step(1); chk("R6 deact on release", seq_state, 3);
    step(DEA - 1); chk("R6 deact length", seq_state, 3);
    step(1); chk("R6 back idle", seq_state, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R3 reset state", seq_state, 0);
    chk("R3 reset no card", status_n, 0);
    chk("R10 reset oe", status_oe, 1);
    chk("R10 reset pull", host_pull_en, 0);
    chk("R8 reset card_rst", card_rst, 0);
    chk("R1 reset vcc", card_vcc_en, 0);

    card_det = 1'b1;
    step(1); chk("R11 one edge", status_n, 0);
    step(1); chk("R11 two edges", status_n, 1);
    card_det = 1'b0;
    step(2); chk("R3 card removed", status_n, 0);

    act_req_n = 1'b0;
    step(6); chk("R2 no card ignored", seq_state, 0);
    chk("R4 no fault status", status_n, 1);
    act_req_n = 1'b1;
    step(2);

    activate_full();
    for (int v = 0; v < 2; v++) begin
      host_rst = v[0];
      step(1); chk("R8 follows in active", card_rst, v);
    end
    pwrdn_req = 1'b1;
    step(4); chk("R9 pd ignored active", seq_state, 2);
    pwrdn_req = 1'b0;
    release_to_idle();
    chk("R8 gated in idle", card_rst, 0);
    host_rst = 1'b0;

    pwrdn_req = 1'b1;
    step(1); chk("R9 pd pending", seq_state, 0);
    step(1); chk("R9 pd entered", seq_state, 4);
    act_req_n = 1'b0;
    step(4); chk("R9 act ignored in pd", seq_state, 4);
    act_req_n = 1'b1;
    step(2);
    pwrdn_req = 1'b0;
    step(2); chk("R9 pd exit", seq_state, 0);

    for (int fk = 0; fk < 4; fk++) begin
      for (int ph = 0; ph < 2; ph++) begin
        if (ph == 0) begin
          act_req_n = 1'b0;
          step(2); chk("R1 entry for fault", seq_state, 1);
        end else begin
          activate_full();
        end
        case (fk)
          0: card_det = 1'b0;
          1: vcc_fault = 1'b1;
          2: therm_fault = 1'b1;
          default: ocp_fault = 1'b1;
        endcase
        step(2); chk("R5 not yet", seq_state, 1 + ph);
        chk("R4 status before latch", status_n, 1);
        step(1); chk("R5 auto deact", seq_state, 3);
        chk("R4 fault status", status_n, 0);
        chk("R5 session drop", session_active, 0);
        chk("R5 vcc drop", card_vcc_en, 0);
        card_det = 1'b1; vcc_fault = 1'b0; therm_fault = 1'b0; ocp_fault = 1'b0;
        step(DEA - 1); chk("R6 deact after fault", seq_state, 3);
        step(1); chk("R6 idle after fault", seq_state, 0);
        chk("R7 latch kept idle", status_n, 0);
        step(4); chk("R7 no reactivation", seq_state, 0);
        chk("R7 latch still", status_n, 0);
        act_req_n = 1'b1;
        step(2); chk("R7 released status", status_n, 1);
        act_req_n = 1'b0;
        step(2); chk("R7 latch cleared restart", seq_state, 1);
        act_req_n = 1'b1;
        step(ACT + DEA + 4); chk("R6 settle idle", seq_state, 0);
      end
    end

    cs = 1'b0;
    #1;
    chk("R10 oe off", status_oe, 0);
    chk("R10 pull on", host_pull_en, 1);
    act_req_n = 1'b0; vsel = 1'b1;
    step(5); chk("R10 req frozen", seq_state, 0);
    chk("R10 vsel frozen", card_vsel, 0);
    cs = 1'b1;
    step(1); chk("R10 vsel live", card_vsel, 1);
    chk("R10 oe back", status_oe, 1);
    step(1); chk("R10 activation after cs", seq_state, 1);
    step(ACT); chk("R10 active", seq_state, 2);
    cs = 1'b0; act_req_n = 1'b1;
    step(5); chk("R10 release frozen", seq_state, 2);
    cs = 1'b1;
    step(1); chk("R10 held one edge", seq_state, 2);
    step(1); chk("R6 deact via cs", seq_state, 3);
    step(DEA); chk("R6 final idle", seq_state, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule